// File: doc/BRIEF.md
# Interrupt-Driven Peripheral Read Interface

This block is a memory-mapped input port placed between a processor bus and a peripheral that delivers words over a valid/ready handshake. Its four registers sit in the ordinary memory space and are reached with plain load and store cycles. To start a transfer, the processor writes a start command. The port then collects one word from the peripheral by itself, so the processor can do other work during the transfer. When the word arrives, the port keeps it in a holding register and flags it in the status register.

Completion can be reported in two ways. In polled operation the port only updates status bits, and the processor must read the status register again to see them. In interrupt operation the port also raises a request line. When the processor acknowledges the request, the port withdraws it and drives its vector number onto the read data bus for that cycle. The word stays held until the processor reads the data register. Only after that read is the port free to accept a new start command.

Top module: `irqrd_port`

## Requirements
- R1: After reset, `irq_req` and `per_ready` are low, the status and control registers read 0, and the vector register reads the parameter `VEC_INIT` (default 8'hA5).
- R2: Register offsets are: `bus_addr` 0 is control (bit0 start, bit1 interrupt enable), 1 is status (bit0 word held, bit1 transfer busy, bit2 sticky error), 2 is the held word, and 3 is the vector. A write to offset 0 with bit0 = 1 while the port is neither busy nor holding a word makes status bit1 read 1 and raises `per_ready` from the next cycle.
- R3: The port takes exactly one word per command: the first cycle with `per_valid` and `per_ready` both high. In the next cycle `per_ready` is low, busy is 0 and word-held is 1. Later `per_valid` pulses are not taken.
- R4: A read of offset 2 returns the held word in the same cycle and clears word-held in the next cycle. Until that read, the held word does not change.
- R5: A start command issued while busy or holding a word is ignored: no new transfer starts and the held word is unchanged. It sets status bit2, which stays set until offset 1 is written with bit2 = 1.
- R6: With control bit1 = 1, `irq_req` rises in the cycle after the word is taken. With control bit1 = 0, `irq_req` never rises, and completion shows only in the status bits.
- R7: While `irq_ack` is high, `bus_rdata` carries the vector register. `irq_req` is low from the next cycle. The acknowledge alone does not clear word-held.
- R8: A bus read in the same cycle as `irq_ack` returns the vector and has no side effect. In particular, a read of offset 2 in that cycle does not clear word-held.
- R9: Writes to offset 2 are ignored. Offset 3 is readable and writable.
- R10: A read of offset 2 also withdraws a pending `irq_req` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus cycle addressed to this port |
| bus_wr | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | DATA_W | Store data |
| bus_rdata | output | DATA_W | Load data, or the vector during acknowledge |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| per_valid | input | 1 | Peripheral offers a word |
| per_data | input | DATA_W | Peripheral word |
| per_ready | output | 1 | Port will take the offered word |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked on purpose.

The first pair is a peripheral word arriving together with a second start command. The bench drives `per_valid` and the control store on the same negedge. The expected result is that the word is captured and the error bit is set, with no new transfer started.

The second pair is an acknowledge overlapping a load of the data register. The bench raises `irq_ack` during a load of offset 2 and checks three things: `bus_rdata` equals the vector, `irq_req` drops, and status still shows the word held until a later plain load.

// File: rtl/irqrd_pkg.sv
package irqrd_pkg;
  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_STAT = 2'd1,
    OFS_DATA = 2'd2,
    OFS_VEC  = 2'd3
  } reg_ofs_e;

  localparam int CTL_GO  = 0;
  localparam int CTL_IEN = 1;
  localparam int ST_ERR  = 2;

  // status layout: {err, busy, held}
  function automatic logic [2:0] pack_status(input logic held, input logic busy,
                                             input logic err);
    return {err, busy, held};
  endfunction
endpackage

// File: rtl/irqrd_decode.sv
module irqrd_decode
  import irqrd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic              go_bit,
  input  logic              irq_ack,
  input  logic [DATA_W-1:0] ctl_val,
  input  logic [DATA_W-1:0] stat_val,
  input  logic [DATA_W-1:0] data_val,
  input  logic [DATA_W-1:0] vec_val,
  output logic              go_strobe,
  output logic              ctl_we,
  output logic              stat_we,
  output logic              vec_we,
  output logic              data_rd,
  output logic [DATA_W-1:0] bus_rdata
);
  logic wr_cyc, rd_cyc;
  reg_ofs_e ofs;

  assign ofs    = reg_ofs_e'(bus_addr);
  assign wr_cyc = bus_sel && bus_wr;
  // an acknowledge owns the read bus, so a load in that cycle has no effect
  assign rd_cyc = bus_sel && !bus_wr && !irq_ack;

  assign ctl_we    = wr_cyc && (ofs == OFS_CTRL);
  assign go_strobe = ctl_we && go_bit;
  assign stat_we   = wr_cyc && (ofs == OFS_STAT);
  assign vec_we    = wr_cyc && (ofs == OFS_VEC);
  assign data_rd   = rd_cyc && (ofs == OFS_DATA);

  always_comb begin
    bus_rdata = '0;
    if (irq_ack) begin
      bus_rdata = vec_val;
    end else if (rd_cyc) begin
      unique case (ofs)
        OFS_CTRL: bus_rdata = ctl_val;
        OFS_STAT: bus_rdata = stat_val;
        OFS_DATA: bus_rdata = data_val;
        OFS_VEC:  bus_rdata = vec_val;
      endcase
    end
  end
endmodule

// File: rtl/irqrd_fetch.sv
module irqrd_fetch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              data_rd,
  input  logic              err_clr,
  input  logic              per_valid,
  input  logic [DATA_W-1:0] per_data,
  output logic              per_ready,
  output logic              busy,
  output logic              held,
  output logic              err,
  output logic              capture,
  output logic [DATA_W-1:0] word
);
  logic busy_q, held_q, err_q;
  logic [DATA_W-1:0] word_q;
  logic engaged, accept_go, reject_go;

  assign engaged   = busy_q || held_q;
  assign accept_go = go && !engaged;
  assign reject_go = go && engaged;
  assign per_ready = busy_q;
  assign capture   = busy_q && per_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      held_q <= 1'b0;
      err_q  <= 1'b0;
      word_q <= '0;
    end else begin
      if (accept_go)    busy_q <= 1'b1;
      else if (capture) busy_q <= 1'b0;

      if (capture)      held_q <= 1'b1;
      else if (data_rd) held_q <= 1'b0;

      if (reject_go)    err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;

      if (capture) word_q <= per_data;
    end
  end

  assign busy = busy_q;
  assign held = held_q;
  assign err  = err_q;
  assign word = word_q;

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_go |=> (busy_q && per_ready));
  p_one_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (!per_ready && held_q));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !data_rd) |=> (held_q && $stable(word_q)));
  p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reject_go && !capture) |=> (err_q && $stable(word_q) && $stable(busy_q)));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/irqrd_intr.sv
module irqrd_intr (
  input  logic clk,
  input  logic rst_n,
  input  logic ien,
  input  logic capture,
  input  logic irq_ack,
  input  logic data_rd,
  output logic irq_req
);
  logic req_q, raise, drop;

  assign raise = capture && ien;
  assign drop  = (irq_ack && req_q) || data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     req_q <= 1'b0;
    else if (raise) req_q <= 1'b1;
    else if (drop)  req_q <= 1'b0;
  end

  assign irq_req = req_q;

  p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> irq_req);
  p_polled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && !irq_req) |=> !irq_req);
  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !capture) |=> !irq_req);
  p_read_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !capture) |=> !irq_req);
endmodule

// File: rtl/irqrd_port.sv
module irqrd_port
  import irqrd_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  VEC_INIT = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  input  logic              irq_ack,
  input  logic              per_valid,
  input  logic [DATA_W-1:0] per_data,
  output logic              per_ready
);
  localparam int PAD_ST  = DATA_W - 3;
  localparam int PAD_CTL = DATA_W - 2;

  logic ien_q;
  logic [DATA_W-1:0] vec_q;
  logic go_strobe, ctl_we, stat_we, vec_we, data_rd;
  logic busy_w, held_w, err_w, capture_w;
  logic [DATA_W-1:0] word_w, ctl_val, stat_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      vec_q <= DATA_W'(VEC_INIT);
    end else begin
      if (ctl_we) ien_q <= bus_wdata[CTL_IEN];
      if (vec_we) vec_q <= bus_wdata;
    end
  end

  assign ctl_val  = {{PAD_CTL{1'b0}}, ien_q, 1'b0};
  assign stat_val = {{PAD_ST{1'b0}}, pack_status(held_w, busy_w, err_w)};

  irqrd_decode #(.DATA_W(DATA_W)) u_decode (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .go_bit   (bus_wdata[CTL_GO]),
    .irq_ack  (irq_ack),
    .ctl_val  (ctl_val),
    .stat_val (stat_val),
    .data_val (word_w),
    .vec_val  (vec_q),
    .go_strobe(go_strobe),
    .ctl_we   (ctl_we),
    .stat_we  (stat_we),
    .vec_we   (vec_we),
    .data_rd  (data_rd),
    .bus_rdata(bus_rdata)
  );

  irqrd_fetch #(.DATA_W(DATA_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go_strobe),
    .data_rd  (data_rd),
    .err_clr  (stat_we && bus_wdata[ST_ERR]),
    .per_valid(per_valid),
    .per_data (per_data),
    .per_ready(per_ready),
    .busy     (busy_w),
    .held     (held_w),
    .err      (err_w),
    .capture  (capture_w),
    .word     (word_w)
  );

  irqrd_intr u_intr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ien    (ien_q),
    .capture(capture_w),
    .irq_ack(irq_ack),
    .data_rd(data_rd),
    .irq_req(irq_req)
  );

  p_ack_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && held_w) |=> held_w);
  p_ack_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && $stable(vec_q)) |-> (bus_rdata == $past(vec_q)));
  p_data_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_w) |=> $stable(word_w));
endmodule

// File: tb/irqrd_port_bench.sv
`timescale 1ns/1ps
module irqrd_port_bench;
  localparam int DW = 8;
  localparam logic [7:0] VINIT = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, irq_ack = 0, per_valid = 0;
  logic [1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, per_data = '0;
  logic [DW-1:0] bus_rdata;
  logic irq_req, per_ready;

  int n_chk = 0, n_bad = 0;
  logic [7:0] cur_vec = VINIT;

  always #10 clk = ~clk;

  irqrd_port #(.DATA_W(DW), .VEC_INIT(VINIT)) u_irqrd_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_ack(irq_ack), .per_valid(per_valid),
    .per_data(per_data), .per_ready(per_ready)
  );

  // expected status: bit0 held, bit1 busy, bit2 error
  function automatic logic [7:0] exp_stat(input bit held, input bit busy, input bit err);
    logic [7:0] s = 8'h00;
    if (held) s = s | 8'h01;
    if (busy) s = s | 8'h02;
    if (err)  s = s | 8'h04;
    return s;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic offer(input logic [7:0] w);
    per_valid = 1; per_data = w;
    @(negedge clk);
    per_valid = 0;
  endtask

  task automatic ack_only(output logic [7:0] d);
    irq_ack = 1;
    #2 d = bus_rdata;
    @(negedge clk);
    irq_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_req", {7'b0, irq_req}, 8'h00);
    check("R1 per_ready", {7'b0, per_ready}, 8'h00);
    bus_read(2'd1, r); check("R1 status", r, 8'h00);
    bus_read(2'd0, r); check("R1 control", r, 8'h00);
    bus_read(2'd3, r); check("R1 vector", r, VINIT);

    // R9 vector register read/write
    bus_write(2'd3, 8'h3C); cur_vec = 8'h3C;
    bus_read(2'd3, r); check("R9 vector rw", r, 8'h3C);

    // R2 / R3 / R4 / R6 polled transfer
    bus_write(2'd0, 8'h01);
    check("R2 per_ready up", {7'b0, per_ready}, 8'h01);
    bus_read(2'd1, r); check("R2 busy status", r, exp_stat(0, 1, 0));
    offer(8'h5A);
    check("R3 per_ready down", {7'b0, per_ready}, 8'h00);
    check("R6 polled no irq", {7'b0, irq_req}, 8'h00);
    offer(8'h77);
    bus_read(2'd1, r); check("R3 held status", r, exp_stat(1, 0, 0));
    bus_read(2'd2, r); check("R4 data read", r, 8'h5A);
    bus_read(2'd1, r); check("R4 held cleared", r, exp_stat(0, 0, 0));

    // R5 rejected starts and sticky error
    bus_write(2'd0, 8'h01);
    bus_write(2'd0, 8'h01);
    bus_read(2'd1, r); check("R5 start while busy", r, exp_stat(0, 1, 1));
    offer(8'h11);
    bus_write(2'd0, 8'h01);
    check("R5 no new transfer", {7'b0, per_ready}, 8'h00);
    bus_read(2'd1, r); check("R5 error sticky", r, exp_stat(1, 0, 1));
    bus_read(2'd2, r); check("R5 word unchanged", r, 8'h11);
    bus_write(2'd1, 8'h04);
    bus_read(2'd1, r); check("R5 error cleared", r, exp_stat(0, 0, 0));

    // R9 data register ignores writes
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, r); check("R9 data write ignored", r, 8'h11);

    // R6 / R7 interrupt with acknowledge
    bus_write(2'd0, 8'h03);
    bus_read(2'd0, r); check("R6 control ien", r, 8'h02);
    offer(8'hC3);
    check("R6 irq raised", {7'b0, irq_req}, 8'h01);
    ack_only(r); check("R7 vector on ack", r, 8'h3C);
    check("R7 irq dropped", {7'b0, irq_req}, 8'h00);
    bus_read(2'd1, r); check("R7 held kept", r, exp_stat(1, 0, 0));
    bus_read(2'd2, r); check("R7 data after ack", r, 8'hC3);

    // R8 acknowledge overlapping a data load
    bus_write(2'd0, 8'h03);
    offer(8'h96);
    irq_ack = 1; bus_sel = 1; bus_wr = 0; bus_addr = 2'd2;
    #2 r = bus_rdata; check("R8 vector wins", r, 8'h3C);
    @(negedge clk); irq_ack = 0; bus_sel = 0;
    check("R8 irq dropped", {7'b0, irq_req}, 8'h00);
    bus_read(2'd1, r); check("R8 no side effect", r, exp_stat(1, 0, 0));
    bus_read(2'd2, r); check("R8 data intact", r, 8'h96);

    // R10 data read withdraws request
    bus_write(2'd0, 8'h03);
    offer(8'h42);
    check("R10 irq raised", {7'b0, irq_req}, 8'h01);
    bus_read(2'd2, r); check("R10 data", r, 8'h42);
    check("R10 irq withdrawn", {7'b0, irq_req}, 8'h00);

    // R5 / R3 word arriving with a second start in the same cycle
    bus_write(2'd0, 8'h01);
    per_valid = 1; per_data = 8'h24;
    bus_write(2'd0, 8'h01);
    per_valid = 0;
    bus_read(2'd1, r); check("R5 same-cycle start", r, exp_stat(1, 0, 1));
    bus_read(2'd2, r); check("R3 same-cycle word", r, 8'h24);
    bus_write(2'd1, 8'h04);

    // random transfers
    for (int i = 0; i < 40; i++) begin
      logic [7:0] w;
      bit ie, use_ack;
      int dly;
      w = 8'($urandom);
      ie = 1'($urandom);
      use_ack = 1'($urandom);
      dly = $urandom_range(0, 4);
      if ($urandom_range(0, 3) == 0) begin
        cur_vec = 8'($urandom);
        bus_write(2'd3, cur_vec);
      end
      bus_write(2'd0, {6'b0, ie, 1'b1});
      repeat (dly) @(negedge clk);
      check("R2 random ready", {7'b0, per_ready}, 8'h01);
      offer(w);
      check("R6 random irq", {7'b0, irq_req}, {7'b0, ie});
      if (ie && use_ack) begin
        ack_only(r); check("R7 random vector", r, cur_vec);
      end
      bus_read(2'd2, r); check("R4 random data", r, w);
      check("R10 random irq low", {7'b0, irq_req}, 8'h00);
      bus_read(2'd1, r); check("R4 random status", r, exp_stat(0, 0, 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule